// File: doc/BRIEF.md
# Register-Mapped Multiply-Accumulate Unit

This block is a multiplier that sits on a simple synchronous register bus. Software loads a first operand at one of four addresses, and the address it picks selects the operation: unsigned product, signed product, unsigned accumulate or signed accumulate. Writing the second operand launches the operation. The 32-bit result and a 16-bit extension word can be read on the very next bus access, with no wait cycles in between.

Operands are 16 bits wide. A byte strobe loads only the low eight bits of the write data. The byte is widened with its top bit in signed modes and with zeros in unsigned modes, so 16x16, 16x8, 8x16 and 8x8 products all use the same registers. In the accumulate modes each new product is added to the result already held. Writing the second operand again repeats the operation with the stored first operand and mode.

The operation mode is held as a four-state machine. The states are `MODE_MPY` (unsigned product, the reset state), `MODE_MPYS` (signed product), `MODE_MAC` (unsigned accumulate) and `MODE_MACS` (signed accumulate). The only transition is a first-operand write, which moves the machine to the state encoded by address bits [2:1] of that write. Every other access leaves the state unchanged.

Top module: `mac_periph`

## Requirements
- R1: After reset the first operand, second operand, result and extension all read 0, and the mode is unsigned product.
- R2: A write to byte address 0x0, 0x2, 0x4 or 0x6 stores the first operand and selects unsigned product, signed product, unsigned accumulate or signed accumulate, in that order. The stored first operand reads back at any of these four addresses.
- R3: A write to 0x8 stores the second operand and computes the result. On the cycle after that write, the low result word reads at 0xA, the high word at 0xC and the extension at 0xE, and 0x8 reads the stored second operand.
- R4: In unsigned product mode the result is the unsigned 32-bit product and the extension is 0.
- R5: In signed product mode the result is the two's-complement product, and the extension is 0xFFFF when that result is negative and 0 otherwise.
- R6: In unsigned accumulate mode the product is added to the held result modulo 2^32, and the extension is 1 when the addition carries out of bit 31 and 0 otherwise.
- R7: In signed accumulate mode the signed product is added to the held result modulo 2^32, and the extension is 0xFFFF when the new result is negative and 0 otherwise.
- R8: When bus_byte is 1, only bus_wdata[7:0] is used. A first-operand byte is widened with bit 7 at 0x2 and 0x6 and with zeros at 0x0 and 0x4. A second-operand byte is widened by the current mode in the same way. The widened value is what reads back.
- R9: Writing only the second operand again repeats the operation with the stored first operand and mode.
- R10: A first-operand write changes neither the result nor the extension.
- R11: Writes to 0xA, 0xC, 0xE and to any odd address change no register. Reads of odd addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Byte address of the access |
| bus_wdata | input | 16 | Write data |
| bus_byte | input | 1 | 1 = byte write (low 8 bits), 0 = word write |
| bus_we | input | 1 | Write enable for this cycle |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |

## Verification
The product is tried with all-ones word operands, which separates a correct 32-bit unsigned product from a truncated one. It is also tried with the most negative value times the most positive value, which exposes a signed product taken as unsigned. Byte writes carry junk in the upper data bits and have bit 7 set, so they separate sign-widening from zero-widening and show whether the upper bits are ignored. The accumulate sequences are chosen so that one step carries out of bit 31 and the next does not, and the signed ones cross zero into a negative sum and then return to zero. This tells the carry extension apart from the sign extension and from a stale value.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;
    // Mode state: bit 0 = signed, bit 1 = accumulate (equal to address bits [2:1])
    typedef enum logic [1:0] {
        MODE_MPY  = 2'd0,
        MODE_MPYS = 2'd1,
        MODE_MAC  = 2'd2,
        MODE_MACS = 2'd3
    } mac_mode_e;

    // Register slots, indexed by address bits [3:1]
    localparam logic [2:0] SLOT_OP2   = 3'd4;
    localparam logic [2:0] SLOT_RESLO = 3'd5;
    localparam logic [2:0] SLOT_RESHI = 3'd6;
    localparam logic [2:0] SLOT_EXT   = 3'd7;
endpackage

// File: rtl/mac_operand_ext.sv
`timescale 1ns/1ps
module mac_operand_ext #(
    parameter int OP_W = 16
) (
    input  logic [OP_W-1:0] din,
    input  logic            is_byte,
    input  logic            sign_en,
    output logic [OP_W-1:0] dout
);
    localparam int BYTE_W = OP_W / 2;

    logic fill;

    always_comb begin
        fill = sign_en & din[BYTE_W-1];
        if (is_byte) dout = {{(OP_W - BYTE_W){fill}}, din[BYTE_W-1:0]};
        else         dout = din;
    end
endmodule

// File: rtl/mac_arith.sv
`timescale 1ns/1ps
module mac_arith
    import mac_pkg::*;
#(
    parameter int OP_W = 16
) (
    input  mac_mode_e         mode,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    input  logic [2*OP_W-1:0] acc,
    output logic [2*OP_W-1:0] res,
    output logic [OP_W-1:0]   ext
);
    localparam int RES_W = 2 * OP_W;

    logic [RES_W-1:0] prod_u;
    logic [RES_W-1:0] prod_s;
    logic [RES_W:0]   sum_u;
    logic [RES_W:0]   sum_s;

    always_comb begin
        prod_u = {{OP_W{1'b0}}, op_a} * {{OP_W{1'b0}}, op_b};
        prod_s = $unsigned($signed({{OP_W{op_a[OP_W-1]}}, op_a}) *
                           $signed({{OP_W{op_b[OP_W-1]}}, op_b}));
        sum_u  = {1'b0, acc} + {1'b0, prod_u};
        sum_s  = {1'b0, acc} + {1'b0, prod_s};
    end

    always_comb begin
        unique case (mode)
            MODE_MPY: begin
                res = prod_u;
                ext = '0;
            end
            MODE_MPYS: begin
                res = prod_s;
                ext = {OP_W{prod_s[RES_W-1]}};
            end
            MODE_MAC: begin
                res = sum_u[RES_W-1:0];
                ext = {{(OP_W-1){1'b0}}, sum_u[RES_W]};
            end
            MODE_MACS: begin
                res = sum_s[RES_W-1:0];
                ext = {OP_W{sum_s[RES_W-1]}};
            end
            default: begin
                res = '0;
                ext = '0;
            end
        endcase
    end
endmodule

// File: rtl/mac_periph.sv
`timescale 1ns/1ps
module mac_periph
    import mac_pkg::*;
#(
    parameter int OP_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      bus_addr,
    input  logic [OP_W-1:0] bus_wdata,
    input  logic            bus_byte,
    input  logic            bus_we,
    output logic [OP_W-1:0] bus_rdata
);
    localparam int RES_W = 2 * OP_W;

    mac_mode_e        state_q, state_d;
    logic [OP_W-1:0]  op1_q, op2_q, ext_q;
    logic [RES_W-1:0] res_q;

    logic [2:0]       slot;
    logic             aligned;
    logic             wr_op1, wr_op2;
    logic             cur_signed;
    logic [OP_W-1:0]  op1_ext, op2_ext, ext_nx;
    logic [RES_W-1:0] res_nx;

    // Access decode
    always_comb begin
        slot    = bus_addr[3:1];
        aligned = ~bus_addr[0];
        wr_op1  = bus_we & aligned & ~slot[2];
        wr_op2  = bus_we & aligned & (slot == SLOT_OP2);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_MPY;
        else        state_q <= state_d;
    end

    // Next state: a first-operand write moves to the mode its address encodes
    always_comb begin
        state_d = state_q;
        if (wr_op1) state_d = mac_mode_e'(slot[1:0]);
    end

    // State outputs
    always_comb begin
        unique case (state_q)
            MODE_MPY, MODE_MAC:   cur_signed = 1'b0;
            MODE_MPYS, MODE_MACS: cur_signed = 1'b1;
            default:              cur_signed = 1'b0;
        endcase
    end

    mac_operand_ext #(.OP_W(OP_W)) u_ext_a (
        .din     (bus_wdata),
        .is_byte (bus_byte),
        .sign_en (slot[0]),
        .dout    (op1_ext)
    );

    mac_operand_ext #(.OP_W(OP_W)) u_ext_b (
        .din     (bus_wdata),
        .is_byte (bus_byte),
        .sign_en (cur_signed),
        .dout    (op2_ext)
    );

    mac_arith #(.OP_W(OP_W)) u_arith (
        .mode (state_q),
        .op_a (op1_q),
        .op_b (op2_ext),
        .acc  (res_q),
        .res  (res_nx),
        .ext  (ext_nx)
    );

    // Operand and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op1_q <= '0;
            op2_q <= '0;
            res_q <= '0;
            ext_q <= '0;
        end else begin
            if (wr_op1) op1_q <= op1_ext;
            if (wr_op2) begin
                op2_q <= op2_ext;
                res_q <= res_nx;
                ext_q <= ext_nx;
            end
        end
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (slot)
                3'd0, 3'd1, 3'd2, 3'd3: bus_rdata = op1_q;
                SLOT_OP2:               bus_rdata = op2_q;
                SLOT_RESLO:             bus_rdata = res_q[OP_W-1:0];
                SLOT_RESHI:             bus_rdata = res_q[RES_W-1:OP_W];
                SLOT_EXT:               bus_rdata = ext_q;
                default:                bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/mac_periph_chk.sv
`timescale 1ns/1ps
module mac_periph_chk #(
    parameter int OP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        bus_addr,
    input logic              bus_we,
    input logic [1:0]        mode_q,
    input logic [2*OP_W-1:0] res_q,
    input logic [OP_W-1:0]   ext_q
);
    logic op1_wr, op2_wr, ro_wr;

    always_comb begin
        op1_wr = bus_we & ~bus_addr[0] & ~bus_addr[3];
        op2_wr = bus_we & ~bus_addr[0] & (bus_addr[3:1] == 3'd4);
        ro_wr  = bus_we & (bus_addr[0] | (bus_addr[3:1] > 3'd4));
    end

    p_mode_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op1_wr |=> (mode_q == $past(bus_addr[2:1])));

    p_mpy_ext_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op2_wr && mode_q == 2'd0) |=> (ext_q == '0));

    p_signed_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op2_wr && mode_q[0]) |=> (ext_q == {OP_W{res_q[2*OP_W-1]}}));

    p_mac_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op2_wr && mode_q == 2'd2) |=> (ext_q[OP_W-1:1] == '0));

    p_op1_keeps_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op1_wr |=> ($stable(res_q) && $stable(ext_q)));

    p_ro_write_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ro_wr |=> ($stable(res_q) && $stable(ext_q) && $stable(mode_q)));
endmodule

bind mac_periph mac_periph_chk #(.OP_W(OP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .mode_q   (state_q),
    .res_q    (res_q),
    .ext_q    (ext_q)
);

// File: tb/sim_mac_periph.sv
`timescale 1ns/1ps
module sim_mac_periph;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_byte = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic probe = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    mac_periph u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_byte  (bus_byte),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata)
    );

    // Driver: one bus access per cycle, driven 1 ns after the rising edge
    task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic b);
        @(posedge clk); #1;
        probe = 1'b0; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_byte = b;
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
        @(posedge clk); #1;
        bus_we = 1'b0; bus_byte = 1'b0; bus_addr = a; probe = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic rd_res(input logic [15:0] lo, input logic [15:0] hi,
                          input logic [15:0] ex, input string tag);
        rd(4'hA, lo, tag);
        rd(4'hC, hi, tag);
        rd(4'hE, ex, tag);
    endtask

    // Monitor: compares on the falling edge
    always @(negedge clk) begin
        if (probe && exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s addr=0x%0h actual=0x%04h expected=0x%04h", t, bus_addr, bus_rdata, e);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd(4'h0, 16'h0000, "R1 op1");
        rd(4'h8, 16'h0000, "R1 op2");
        rd_res(16'h0000, 16'h0000, 16'h0000, "R1 result");

        // R4, R3, R2: unsigned word product, read right after the trigger
        wr(4'h0, 16'hFFFF, 1'b0);
        wr(4'h8, 16'hFFFF, 1'b0);
        rd_res(16'h0001, 16'hFFFE, 16'h0000, "R4 R3 mpy word");
        rd(4'h6, 16'hFFFF, "R2 op1 alias");
        rd(4'h8, 16'hFFFF, "R3 op2 readback");

        // R5: signed most-negative times most-positive
        wr(4'h2, 16'h8000, 1'b0);
        wr(4'h8, 16'h7FFF, 1'b0);
        rd_res(16'h8000, 16'hC000, 16'hFFFF, "R5 mpys");

        // R8: signed byte operands with junk upper bits
        wr(4'h2, 16'h1280, 1'b1);
        rd(4'h2, 16'hFF80, "R8 op1 sign widen");
        wr(4'h8, 16'h5A03, 1'b1);
        rd_res(16'hFE80, 16'hFFFF, 16'hFFFF, "R8 R5 mpys byte");

        // R8: unsigned byte operands
        wr(4'h0, 16'hAB80, 1'b1);
        rd(4'h0, 16'h0080, "R8 op1 zero widen");
        wr(4'h8, 16'h0100, 1'b0);
        rd_res(16'h8000, 16'h0000, 16'h0000, "R4 mpy 8x16");
        wr(4'h8, 16'h77FF, 1'b1);
        rd(4'h8, 16'h00FF, "R8 op2 zero widen");
        rd_res(16'h7F80, 16'h0000, 16'h0000, "R8 mpy 8x8");

        // R6, R9, R10: unsigned accumulate with and without carry
        wr(4'h0, 16'hFFFF, 1'b0);
        wr(4'h8, 16'hFFFF, 1'b0);
        wr(4'h4, 16'hFFFF, 1'b0);
        rd_res(16'h0001, 16'hFFFE, 16'h0000, "R10 op1 write keeps result");
        wr(4'h8, 16'hFFFF, 1'b0);
        rd_res(16'h0002, 16'hFFFC, 16'h0001, "R6 mac carry");
        wr(4'h8, 16'hFFFF, 1'b0);
        rd_res(16'h0003, 16'hFFFA, 16'h0001, "R9 R6 mac repeat");
        wr(4'h8, 16'h0001, 1'b0);
        rd_res(16'h0002, 16'hFFFB, 16'h0000, "R6 mac no carry");

        // R7, R9: signed accumulate crossing zero
        wr(4'h2, 16'h0002, 1'b0);
        wr(4'h8, 16'h0003, 1'b0);
        rd_res(16'h0006, 16'h0000, 16'h0000, "R5 mpys positive");
        wr(4'h6, 16'hFFFF, 1'b0);
        rd_res(16'h0006, 16'h0000, 16'h0000, "R10 op1 write keeps result");
        wr(4'h8, 16'h0004, 1'b0);
        rd_res(16'h0002, 16'h0000, 16'h0000, "R7 macs");
        wr(4'h8, 16'h0004, 1'b0);
        rd_res(16'hFFFE, 16'hFFFF, 16'hFFFF, "R9 R7 macs negative");
        wr(4'h8, 16'h33FE, 1'b1);
        rd(4'h8, 16'hFFFE, "R8 op2 sign widen");
        rd_res(16'h0000, 16'h0000, 16'h0000, "R7 R8 macs back to zero");

        // R11: read-only and odd-address writes
        wr(4'hA, 16'h1234, 1'b0);
        wr(4'hC, 16'h5678, 1'b0);
        wr(4'hE, 16'h0009, 1'b0);
        wr(4'h1, 16'h4321, 1'b0);
        wr(4'h9, 16'h2222, 1'b0);
        rd_res(16'h0000, 16'h0000, 16'h0000, "R11 result unchanged");
        rd(4'h0, 16'hFFFF, "R11 op1 unchanged");
        rd(4'h8, 16'hFFFE, "R11 op2 unchanged");
        rd(4'h3, 16'h0000, "R11 odd read");
        wr(4'h8, 16'h0001, 1'b0);
        rd_res(16'hFFFF, 16'hFFFF, 16'hFFFF, "R11 R2 mode still macs");

        @(posedge clk); #1;
        probe = 1'b0;
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule